// File: doc/BRIEF.md
# Direct Serial Command Engine

This block lets software talk to a serial memory device one byte at a time, bypassing any memory-mapped access path. Software programs a control word (enable, clock divider, chip-select policy), then writes a byte plus per-transfer options (lane width, output enable, discard of received data) to a transmit register. The engine clocks the byte out on one, two or four data lanes while capturing the same number of symbols from the device, and leaves the captured byte in a receive register for software to take.

Chip select can be held low by software across several bytes (for multi-byte commands) or raised and lowered by the engine around each byte. The transmit and receive buffers each hold one entry, so a second byte may be queued while the first is shifting. Writing zero to the control register stops everything and releases chip select.

Top module: `sdx_engine`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0x0000_0800 (only the tx-empty bit 11 set), `csN` is high, `sclk` is low and `sdOe` is zero.
- R2: A write to the transmit register (offset 0x4) while enabled sets busy (control bit 1) from the next cycle until the last serial clock falling edge of the transfer (or of a queued next transfer); tx-empty (control bit 11) goes high once the byte has moved into the shifter and is low while a byte waits in the buffer.
- R3: `sclk` idles low; each high and each low half lasts D system cycles, where D is control bits 29:22 (0 is treated as 1); a byte takes 8, 4 or 2 serial clock pulses for one, two or four lanes.
- R4: Transmit bits 17:16 pick the lane width: 0 drives `sdOut[0]` and samples `sdIn[1]`; 1 uses lanes 1:0; 2 (and 3) use lanes 3:0. The byte (transmit bits 7:0) goes out most significant symbol first, higher lane carrying the higher bit.
- R5: `sdOut` changes only while `sclk` is low (on falling edges); the first symbol is present before the first rising edge, and input is sampled on rising edges.
- R6: During a transfer `sdOe` equals the lane mask (0001, 0011 or 1111) when transmit bit 19 is set and 0000 otherwise; it is 0000 when idle.
- R7: At the end of a transfer the captured byte replaces the receive register (offset 0x8), unless transmit bit 20 (no-push) was set, in which case the receive register is left as it was.
- R8: A read of the receive register returns the held byte in bits 7:0 and clears it to zero for later reads.
- R9: A transmit write while the buffer already holds a byte is ignored, and a transmit write while enable (control bit 0) is low is ignored.
- R10: With enable and control bit 3 set, `csN` is low continuously, with or without a transfer.
- R11: With enable and control bit 7 set, `csN` is low while a byte is shifting (including every rising `sclk` edge) and high when idle.
- R12: Writing the control register with enable low stops a running transfer, drops any queued byte, raises `csN`, returns `sclk` low within one cycle and pushes nothing to the receive register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops the receive register at offset 0x8) |
| regAddr | input | 4 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| sdOut | output | 4 | Serial data out, one bit per lane |
| sdOe | output | 4 | Per-lane output enable |
| sdIn | input | 4 | Serial data in, one bit per lane |

## Verification
The bench sweeps every lane-width code against four divider values, one of them zero, with distinct outgoing and incoming bytes per point, so a lane swap, a bit-order error, a wrong pulse count or a wrong half-period each shows as a different mismatch at the device model. Output enable alternates across the sweep to separate the enabled and tri-stated lane masks, and no-push is mixed in to tell capture from discard. Separate sequences queue a second and third byte behind a slow transfer, write while disabled, toggle manual chip select, and abort a transfer with a byte queued, each observed through the pins and register reads.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  localparam int REG_AW = 4;

  // register offsets
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFS_TX   = 4'h4;
  localparam logic [REG_AW-1:0] OFS_RX   = 4'h8;

  // control word fields
  localparam int B_EN      = 0;
  localparam int B_BUSY    = 1;
  localparam int B_CSMAN   = 3;
  localparam int B_CSAUTO  = 7;
  localparam int B_TXEMPTY = 11;
  localparam int B_DIV_LO  = 22;
  localparam int B_DIV_HI  = 29;
  localparam int DIV_W     = B_DIV_HI - B_DIV_LO + 1;

  // transmit word fields
  localparam int B_WIDTH_LO = 16;
  localparam int B_OE       = 19;
  localparam int B_NOPUSH   = 20;

  typedef enum logic [1:0] {
    LW_X1    = 2'd0,
    LW_X2    = 2'd1,
    LW_X4    = 2'd2,
    LW_X4ALT = 2'd3
  } lane_w_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
    logic abort;
  } step_t;

endpackage

// File: rtl/sdx_ctrl.sv
module sdx_ctrl
  import sdx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             wrEn,
  input  logic             wrCsMan,
  input  logic             wrCsAuto,
  input  logic [DIV_W-1:0] wrDiv,
  input  logic             txFull,
  input  logic [1:0]       pendWidth,
  output step_t            step,
  output logic             sclk,
  output logic             csN,
  output logic             enable,
  output logic             csManual,
  output logic             csAuto,
  output logic [DIV_W-1:0] divVal,
  output logic             running
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] halfLen;
  logic [CNT_W-1:0] pulsesLeft;
  logic [CNT_W-1:0] pulsesInit;
  logic             tick;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      csManual <= 1'b0;
      csAuto   <= 1'b0;
      divVal   <= '0;
    end else if (ctrlWr) begin
      enable   <= wrEn;
      csManual <= wrCsMan;
      csAuto   <= wrCsAuto;
      divVal   <= wrDiv;
    end
  end

  assign halfLen = (divVal == '0) ? DIV_W'(1) : divVal;

  always_comb begin
    case (lane_w_e'(pendWidth))
      LW_X1:   pulsesInit = CNT_W'(DATA_W);
      LW_X2:   pulsesInit = CNT_W'(DATA_W / 2);
      default: pulsesInit = CNT_W'(DATA_W / 4);
    endcase
  end

  assign tick = running && enable && (halfCnt == '0);

  always_comb begin
    step        = '0;
    step.abort  = !enable;
    step.load   = enable && !running && txFull;
    step.sample = tick && !sclk;
    step.shift  = tick && sclk && (pulsesLeft != CNT_W'(1));
    step.finish = tick && sclk && (pulsesLeft == CNT_W'(1));
  end

  // serial clock sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      sclk       <= 1'b0;
      halfCnt    <= '0;
      pulsesLeft <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      sclk    <= 1'b0;
      halfCnt <= '0;
    end else if (step.load) begin
      running    <= 1'b1;
      sclk       <= 1'b0;
      halfCnt    <= halfLen - DIV_W'(1);
      pulsesLeft <= pulsesInit;
    end else if (running) begin
      if (halfCnt != '0) begin
        halfCnt <= halfCnt - DIV_W'(1);
      end else begin
        halfCnt <= halfLen - DIV_W'(1);
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (pulsesLeft == CNT_W'(1)) running <= 1'b0;
          else pulsesLeft <= pulsesLeft - CNT_W'(1);
        end
      end
    end
  end

  assign csN = !(enable && (csManual || (csAuto && running)));

endmodule

// File: rtl/sdx_datapath.sv
module sdx_datapath
  import sdx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  step_t             step,
  input  logic              running,
  input  logic              txWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wrWidth,
  input  logic              wrOe,
  input  logic              wrNoPush,
  input  logic              rxPop,
  input  logic [3:0]        sdIn,
  output logic              txFull,
  output logic [1:0]        pendWidth,
  output logic [3:0]        sdOut,
  output logic [3:0]        sdOe,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txData;
  logic              txOe;
  logic              txNoPush;
  logic [1:0]        shWidth;
  logic              shOe;
  logic              shNoPush;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] nextTx;
  logic [DATA_W-1:0] nextRx;
  logic [3:0]        outSym;
  logic [3:0]        laneMask;
  logic              accept;

  assign accept = txWr && !txFull && !step.abort;

  // one-entry transmit buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull    <= 1'b0;
      txData    <= '0;
      pendWidth <= '0;
      txOe      <= 1'b0;
      txNoPush  <= 1'b0;
    end else if (step.abort || step.load) begin
      txFull <= 1'b0;
    end else if (accept) begin
      txFull    <= 1'b1;
      txData    <= wrData;
      pendWidth <= wrWidth;
      txOe      <= wrOe;
      txNoPush  <= wrNoPush;
    end
  end

  // lane-dependent shift and symbol selection
  always_comb begin
    case (lane_w_e'(shWidth))
      LW_X1: begin
        nextTx   = {txShift[DATA_W-2:0], 1'b0};
        nextRx   = {rxShift[DATA_W-2:0], sdIn[1]};
        outSym   = {3'b000, txShift[DATA_W-1]};
        laneMask = 4'b0001;
      end
      LW_X2: begin
        nextTx   = {txShift[DATA_W-3:0], 2'b00};
        nextRx   = {rxShift[DATA_W-3:0], sdIn[1:0]};
        outSym   = {2'b00, txShift[DATA_W-1 -: 2]};
        laneMask = 4'b0011;
      end
      default: begin
        nextTx   = {txShift[DATA_W-5:0], 4'b0000};
        nextRx   = {rxShift[DATA_W-5:0], sdIn};
        outSym   = txShift[DATA_W-1 -: 4];
        laneMask = 4'b1111;
      end
    endcase
  end

  // shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      shWidth  <= '0;
      shOe     <= 1'b0;
      shNoPush <= 1'b0;
    end else if (step.load) begin
      txShift  <= txData;
      rxShift  <= '0;
      shWidth  <= pendWidth;
      shOe     <= txOe;
      shNoPush <= txNoPush;
    end else begin
      if (step.shift)  txShift <= nextTx;
      if (step.sample) rxShift <= nextRx;
    end
  end

  // one-entry receive buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (step.finish && !shNoPush) begin
      rxData <= rxShift;
    end else if (rxPop) begin
      rxData <= '0;
    end
  end

  assign sdOut = running ? outSym : 4'b0000;
  assign sdOe  = (running && shOe) ? laneMask : 4'b0000;

endmodule

// File: rtl/sdx_engine.sv
module sdx_engine
  import sdx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              sclk,
  output logic              csN,
  output logic [3:0]        sdOut,
  output logic [3:0]        sdOe,
  input  logic [3:0]        sdIn
);

  step_t             stepW;
  logic              enableW;
  logic              csManualW;
  logic              csAutoW;
  logic [DIV_W-1:0]  divW;
  logic              runningW;
  logic              txFullW;
  logic [1:0]        pendWidthW;
  logic [DATA_W-1:0] rxDataW;
  logic              busyW;
  logic              ctrlWr;
  logic              txWr;
  logic              rxPop;

  assign ctrlWr = regWr && (regAddr == OFS_CTRL);
  assign txWr   = regWr && (regAddr == OFS_TX);
  assign rxPop  = regRd && (regAddr == OFS_RX);
  assign busyW  = txFullW || runningW;

  sdx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .wrEn      (regWdata[B_EN]),
    .wrCsMan   (regWdata[B_CSMAN]),
    .wrCsAuto  (regWdata[B_CSAUTO]),
    .wrDiv     (regWdata[B_DIV_HI:B_DIV_LO]),
    .txFull    (txFullW),
    .pendWidth (pendWidthW),
    .step      (stepW),
    .sclk      (sclk),
    .csN       (csN),
    .enable    (enableW),
    .csManual  (csManualW),
    .csAuto    (csAutoW),
    .divVal    (divW),
    .running   (runningW)
  );

  sdx_datapath #(.DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .step      (stepW),
    .running   (runningW),
    .txWr      (txWr),
    .wrData    (regWdata[DATA_W-1:0]),
    .wrWidth   (regWdata[B_WIDTH_LO +: 2]),
    .wrOe      (regWdata[B_OE]),
    .wrNoPush  (regWdata[B_NOPUSH]),
    .rxPop     (rxPop),
    .sdIn      (sdIn),
    .txFull    (txFullW),
    .pendWidth (pendWidthW),
    .sdOut     (sdOut),
    .sdOe      (sdOe),
    .rxData    (rxDataW)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CTRL: begin
        regRdata[B_EN]              = enableW;
        regRdata[B_BUSY]            = busyW;
        regRdata[B_CSMAN]           = csManualW;
        regRdata[B_CSAUTO]          = csAutoW;
        regRdata[B_TXEMPTY]         = !txFullW;
        regRdata[B_DIV_HI:B_DIV_LO] = divW;
      end
      OFS_RX:  regRdata[DATA_W-1:0] = rxDataW;
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/sdx_checker.sv
module sdx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclk,
  input logic       csN,
  input logic [3:0] sdOut,
  input logic [3:0] sdOe,
  input logic       busy,
  input logic       running,
  input logic       enable
);

  p_busy_clock_r2: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> busy);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !sclk);

  p_out_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdOut));

  p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (sdOe == 4'b0000));

  p_oe_shape_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sdOe) || (sdOe == 4'b0011) || (sdOe == 4'b1111));

  p_cs_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> csN);

  p_abort_stop_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !running);

endmodule

bind sdx_engine sdx_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .sclk    (sclk),
  .csN     (csN),
  .sdOut   (sdOut),
  .sdOe    (sdOe),
  .busy    (busyW),
  .running (runningW),
  .enable  (enableW)
);

// File: tb/sim_sdx_engine.sv
module sim_sdx_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic        sclk;
  logic        csN;
  logic [3:0]  sdOut;
  logic [3:0]  sdOe;
  logic [3:0]  sdIn = 4'h0;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_TX   = 4'h4;
  localparam logic [3:0] A_RX   = 4'h8;

  always #2 clk = ~clk;

  sdx_engine #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .csN(csN),
    .sdOut(sdOut), .sdOe(sdOe), .sdIn(sdIn)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  // device model state
  logic [7:0] devByte = 8'h00;
  int         devWidth = 0;
  int         devPulses = 8;
  int         riseCount = 0;
  logic [7:0] devRx = 8'h00;
  logic [3:0] oeAtRise = 4'h0;
  bit         csLowAll = 1;
  int         riseCyc = 0;
  int         lastPeriod = 0;
  int         lastHigh = 0;
  logic [7:0] rxModel = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] sym(input logic [7:0] b, input int w, input int idx);
    case (w)
      0:       return {2'b00, b[7-idx], 1'b0};
      1:       return {2'b00, b[7-2*idx -: 2]};
      default: return b[7-4*idx -: 4];
    endcase
  endfunction

  always @(posedge sclk) begin
    if (riseCount > 0) lastPeriod = cyc - riseCyc;
    riseCyc = cyc;
    riseCount = riseCount + 1;
    case (devWidth)
      0:       devRx = {devRx[6:0], sdOut[0]};
      1:       devRx = {devRx[5:0], sdOut[1:0]};
      default: devRx = {devRx[3:0], sdOut};
    endcase
    oeAtRise = sdOe;
    if (csN) csLowAll = 0;
  end

  always @(negedge sclk) begin
    lastHigh = cyc - riseCyc;
    sdIn = sym(devByte, devWidth, riseCount % devPulses);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    int n = 0;
    do begin
      rd(A_CTRL, v);
      n++;
    end while (v[1] && n < 5000);
    @(negedge clk);
  endtask

  task automatic setDev(input logic [7:0] b, input int w);
    devByte = b;
    devWidth = (w == 3) ? 2 : w;
    devPulses = 8 >> devWidth;
    riseCount = 0;
    csLowAll = 1;
    devRx = 8'h00;
    sdIn = sym(b, devWidth, 0);
  endtask

  task automatic xfer(input logic [7:0] data, input int w, input bit oe, input bit np,
                      input int div, input logic [7:0] dbyte);
    logic [31:0] v;
    int effD;
    logic [3:0] mask;
    effD = (div == 0) ? 1 : div;
    wr(A_CTRL, (32'(div) << 22) | 32'h81);
    setDev(dbyte, w);
    mask = (devWidth == 0) ? 4'b0001 : (devWidth == 1) ? 4'b0011 : 4'b1111;
    wr(A_TX, {11'd0, np, oe, 1'b0, 2'(w), 8'd0, data});
    waitIdle();
    check("R3 pulse count", riseCount, devPulses);
    check("R3 period", lastPeriod, 2 * effD);
    check("R3 high half", lastHigh, effD);
    check("R4 R5 lane data", devRx, data);
    check("R6 oe mask", oeAtRise, oe ? mask : 4'b0000);
    check("R11 cs low at rises", csLowAll, 1);
    check("R11 cs high idle", csN, 1'b1);
    rd(A_RX, v);
    check("R7 rx capture", v, np ? rxModel : dbyte);
    rxModel = 8'h00;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int divs[4];
    int abortRises;
    divs[0] = 0; divs[1] = 1; divs[2] = 2; divs[3] = 5;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);
    check("R1 ctrl reset", v, 32'h0000_0800);
    check("R1 csN", csN, 1'b1);
    check("R1 sclk", sclk, 1'b0);
    check("R1 sdOe", sdOe, 4'h0);

    // R3..R7, R11 sweep over widths and dividers
    for (int w = 0; w < 4; w++) begin
      for (int di = 0; di < 4; di++) begin
        xfer(8'(8'h5A ^ (w * 53) ^ (di * 29)), w, di[0] == 1'b0, di == 3,
             divs[di], 8'(8'hC3 + w * 17 + di * 71));
      end
    end

    // R8 second read returns zero
    wr(A_CTRL, 32'h81);
    setDev(8'h96, 0);
    wr(A_TX, 32'h0008_0033);
    waitIdle();
    rd(A_RX, v);
    check("R8 first read", v, 32'h96);
    rd(A_RX, v);
    check("R8 cleared after read", v, 32'h0);

    // R2 busy/tx-empty and R9 write while full
    wr(A_CTRL, (32'd8 << 22) | 32'h81);
    setDev(8'h3C, 0);
    wr(A_TX, 32'h0008_00A1);
    rd(A_CTRL, v);
    check("R2 busy after write", v[1], 1'b1);
    check("R2 tx empty once taken", v[11], 1'b1);
    wr(A_TX, 32'h0008_00B2);
    rd(A_CTRL, v);
    check("R2 tx empty low when queued", v[11], 1'b0);
    wr(A_TX, 32'h0008_00C3);
    waitIdle();
    check("R9 two transfers only", riseCount, 16);
    check("R9 queued byte sent", devRx, 8'hB2);
    rd(A_RX, v);
    check("R7 rx after queued", v, 32'h3C);

    // R9 write while disabled
    wr(A_CTRL, 32'h0);
    riseCount = 0;
    wr(A_TX, 32'h0008_0055);
    wr(A_CTRL, 32'h81);
    repeat (20) @(negedge clk);
    rd(A_CTRL, v);
    check("R9 disabled write busy", v[1], 1'b0);
    check("R9 disabled write no pulses", riseCount, 0);

    // R10 manual chip select
    wr(A_CTRL, 32'h09);
    @(negedge clk);
    check("R10 manual cs low", csN, 1'b0);
    repeat (5) @(negedge clk);
    check("R10 manual cs held", csN, 1'b0);
    wr(A_CTRL, 32'h01);
    check("R10 manual cs released", csN, 1'b1);

    // R12 abort with a byte queued
    wr(A_CTRL, (32'd20 << 22) | 32'h81);
    setDev(8'hE7, 0);
    wr(A_TX, 32'h0008_0011);
    wr(A_TX, 32'h0008_0022);
    repeat (60) @(negedge clk);
    wr(A_CTRL, 32'h0);
    check("R12 cs released", csN, 1'b1);
    @(negedge clk);
    check("R12 sclk low", sclk, 1'b0);
    rd(A_CTRL, v);
    check("R12 not busy", v[1], 1'b0);
    abortRises = riseCount;
    wr(A_CTRL, 32'h81);
    repeat (300) @(negedge clk);
    check("R12 queued byte dropped", riseCount, abortRises);
    rd(A_RX, v);
    check("R12 nothing pushed", v, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule